// File: doc/BRIEF.md
# Three-Phase Sine-Triangle Gate Generator with Dead-Time

This block turns three signed sine reference samples into six gate drive signals for a three-leg voltage inverter. A single symmetric triangle carrier is shared by all phases. It is built as an up-down counter that spans the same range as the references. Each phase compares its own reference with the carrier. The result drives the upper switch of that leg, and the inverse drives the lower switch.

The carrier step rate is chosen at run time by an 8-bit code that feeds a clock-enable divider. Before it reaches a pin, every gate signal passes through a dead-time stage. This stage delays only 0-to-1 transitions, by a programmable number of ticks of a slower dead-time clock, so the two switches of a leg are never commanded on together. A 1-to-0 transition passes after a single register stage.

The references are produced upstream. The block only samples them each clock.

Top module: `spwm_gate_gen`

## Requirements
- R1: While `rst_n` is low, all six gate outputs are 0, whatever the other inputs are.
- R2: The carrier moves one step at a time from -127 up to +127 and back down. It turns at each extreme without holding that value for a second step. After reset it starts at -127 and counts upward.
- R3: The carrier takes one step every `carrier_code`+1 clock cycles, so code 0 steps on every cycle. One full carrier period therefore lasts 508×(`carrier_code`+1) cycles.
- R4: The raw upper signal of a phase is 1 only when that phase's reference (8-bit two's complement) is strictly greater than the carrier. With dead-time 0 and reference +127, `gate_hi` is high for 507×(code+1) cycles of every period. With reference -127 it is never high.
- R5: The raw lower signal of a phase is the inverse of its raw upper signal. With dead-time 0, `gate_lo` is high whenever `gate_hi` is low, one register after the comparison.
- R6: A 0-to-1 transition on any raw gate signal reaches the output only after `dead_setting` ticks of the dead-time clock (one tick every DT_PRESCALE cycles). With DT_PRESCALE=4 and a setting of s≥1, the output goes high on clock edge number 4(s-1)+2 to 4s+1 after the input change. A 1-to-0 transition reaches the output on the first edge.
- R7: A dead-time setting of 0 adds no delay: a rising raw signal shows at the output on the first clock edge.
- R8: When the raw signal falls back to 0 before its dead-time has expired, the pending rising edge is dropped and the output stays 0.
- R9: `gate_hi[p]` and `gate_lo[p]` are never 1 in the same cycle.
- R10: The phases are independent. Bit p of both gate vectors belongs to phase p (a=0, b=1, c=2) and follows only that phase's reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| carrier_code | input | 8 | Carrier step interval minus one, in clock cycles |
| dead_setting | input | 4 | Rising-edge delay in dead-time clock ticks |
| ref_a | input | 8 | Phase a reference, signed |
| ref_b | input | 8 | Phase b reference, signed |
| ref_c | input | 8 | Phase c reference, signed |
| gate_hi | output | 3 | Upper switch gates, bit p = phase p |
| gate_lo | output | 3 | Lower switch gates, bit p = phase p |

## Verification
The assertions assume that every reference sample is a valid two's complement byte and that the carrier code and dead-time setting are stable inputs rather than glitching ones. They accept changes to these inputs at any clock edge. The bench drives every input at the falling clock edge. It changes the carrier code only between measurement windows and lets the divider settle before counting. Reference steps for the dead-time cases are made right after a reset with the slowest carrier code, so the carrier is still near -127 and the strict comparison result is certain at the moment of the step.

// File: rtl/spwm_pkg.sv
package spwm_pkg;
  localparam int REF_W   = 8;
  localparam int NUM_PH  = 3;

  typedef logic signed [REF_W-1:0] sample_t;

  localparam sample_t CAR_TOP = sample_t'((1 << (REF_W - 1)) - 1);
  localparam sample_t CAR_BOT = sample_t'(-((1 << (REF_W - 1)) - 1));

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } car_dir_e;
endpackage

// File: rtl/spwm_rate_div.sv
module spwm_rate_div #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] code,
  output logic         tick
);
  logic [W-1:0] cnt_q, cnt_d;

  // tick fires once cnt reaches code; ">=" keeps a lowered code from overrunning
  always_comb begin
    tick  = (cnt_q >= code);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3: after a tick the count restarts from zero
  a_r3_restart_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == '0));
endmodule

// File: rtl/spwm_carrier.sv
module spwm_carrier
  import spwm_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    step_en,
  output sample_t carrier
);
  sample_t  car_q, car_d;
  car_dir_e dir_q, dir_d;

  always_comb begin
    car_d = car_q;
    dir_d = dir_q;
    if (step_en) begin
      if (dir_q == DIR_UP) begin
        if (car_q >= CAR_TOP) begin
          dir_d = DIR_DOWN;
          car_d = car_q - sample_t'(1);
        end else begin
          car_d = car_q + sample_t'(1);
        end
      end else begin
        if (car_q <= CAR_BOT) begin
          dir_d = DIR_UP;
          car_d = car_q + sample_t'(1);
        end else begin
          car_d = car_q - sample_t'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      car_q <= CAR_BOT;
      dir_q <= DIR_UP;
    end else begin
      car_q <= car_d;
      dir_q <= dir_d;
    end
  end

  assign carrier = car_q;

  // R2: carrier never leaves the symmetric range
  a_r2_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (car_q <= CAR_TOP) && (car_q >= CAR_BOT));
  // R2: extremes are not repeated
  a_r2_turn_at_top: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && car_q == CAR_TOP) |=> (car_q == CAR_TOP - sample_t'(1)));
  a_r2_turn_at_bottom: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && car_q == CAR_BOT) |=> (car_q == CAR_BOT + sample_t'(1)));
  // R3: carrier moves only on an enable
  a_r3_hold_between_steps: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(car_q));
endmodule

// File: rtl/spwm_dead_band.sv
module spwm_dead_band #(
  parameter int DT_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dt_tick,
  input  logic [DT_W-1:0] setting,
  input  logic            raw,
  output logic            gate
);
  logic            gate_q, gate_d;
  logic [DT_W-1:0] wait_q, wait_d;

  always_comb begin
    gate_d = gate_q;
    wait_d = wait_q;
    if (!raw) begin
      gate_d = 1'b0;
      wait_d = '0;
    end else if (!gate_q) begin
      if (wait_q >= setting) begin
        gate_d = 1'b1;
      end else if (dt_tick) begin
        wait_d = wait_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      wait_q <= '0;
    end else begin
      gate_q <= gate_d;
      wait_q <= wait_d;
    end
  end

  assign gate = gate_q;

  // R6: a falling raw signal clears the gate on the next edge
  a_r6_fall_next_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !raw |=> !gate_q);
  // R6: no rise while the delay count is short of the setting
  a_r6_hold_during_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_q && wait_q < setting) |=> !gate_q);
  // R8: a rise always follows a raw high that persisted
  a_r8_rise_needs_raw: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_q) |-> $past(raw));
endmodule

// File: rtl/spwm_leg.sv
module spwm_leg
  import spwm_pkg::*;
#(
  parameter int DT_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dt_tick,
  input  logic [DT_W-1:0] setting,
  input  sample_t         ref_smp,
  input  sample_t         carrier,
  output logic            gate_hi,
  output logic            gate_lo
);
  logic raw_hi, raw_lo;

  assign raw_hi = (ref_smp > carrier);
  assign raw_lo = ~raw_hi;

  spwm_dead_band #(.DT_W(DT_W)) u_db_hi (
    .clk(clk), .rst_n(rst_n), .dt_tick(dt_tick), .setting(setting),
    .raw(raw_hi), .gate(gate_hi)
  );

  spwm_dead_band #(.DT_W(DT_W)) u_db_lo (
    .clk(clk), .rst_n(rst_n), .dt_tick(dt_tick), .setting(setting),
    .raw(raw_lo), .gate(gate_lo)
  );

  // R9: switches of one leg never on together
  a_r9_no_shoot_through: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi && gate_lo));
  // R5: a compare win turns the lower switch off on the next edge
  a_r5_lo_off_when_hi_wins: assert property (@(posedge clk) disable iff (!rst_n)
    raw_hi |=> !gate_lo);
  // R4: a compare loss turns the upper switch off on the next edge
  a_r4_hi_off_when_lost: assert property (@(posedge clk) disable iff (!rst_n)
    !raw_hi |=> !gate_hi);
endmodule

// File: rtl/spwm_gate_gen.sv
module spwm_gate_gen
  import spwm_pkg::*;
#(
  parameter int CODE_W      = 8,
  parameter int DT_W        = 4,
  parameter int DT_PRESCALE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] carrier_code,
  input  logic [DT_W-1:0]   dead_setting,
  input  logic [REF_W-1:0]  ref_a,
  input  logic [REF_W-1:0]  ref_b,
  input  logic [REF_W-1:0]  ref_c,
  output logic [NUM_PH-1:0] gate_hi,
  output logic [NUM_PH-1:0] gate_lo
);
  localparam int PS_W = (DT_PRESCALE > 1) ? $clog2(DT_PRESCALE) : 1;
  localparam logic [PS_W-1:0] PS_CODE = PS_W'(DT_PRESCALE - 1);

  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic    car_tick, dt_tick;
  sample_t carrier;
  sample_t refs [NUM_PH];

  assign refs[0] = sample_t'(ref_a);
  assign refs[1] = sample_t'(ref_b);
  assign refs[2] = sample_t'(ref_c);

  spwm_rate_div #(.W(CODE_W)) u_car_div (
    .clk(clk), .rst_n(rst_int_n), .code(carrier_code), .tick(car_tick)
  );

  spwm_rate_div #(.W(PS_W)) u_dt_div (
    .clk(clk), .rst_n(rst_int_n), .code(PS_CODE), .tick(dt_tick)
  );

  spwm_carrier u_carrier (
    .clk(clk), .rst_n(rst_int_n), .step_en(car_tick), .carrier(carrier)
  );

  for (genvar p = 0; p < NUM_PH; p++) begin : g_leg
    spwm_leg #(.DT_W(DT_W)) u_leg (
      .clk(clk), .rst_n(rst_int_n), .dt_tick(dt_tick), .setting(dead_setting),
      .ref_smp(refs[p]), .carrier(carrier),
      .gate_hi(gate_hi[p]), .gate_lo(gate_lo[p])
    );
  end

  // R1: gates held low while reset is applied
  a_r1_reset_gates_low: assert property (@(posedge clk)
    !rst_n |-> (gate_hi == '0 && gate_lo == '0));
endmodule

// File: tb/spwm_gate_gen_bench.sv
module spwm_gate_gen_bench;
  localparam int P = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] carrier_code;
  logic [3:0] dead_setting;
  logic [7:0] ref_a, ref_b, ref_c;
  logic [2:0] gate_hi, gate_lo;

  int total = 0;
  int bad   = 0;
  int overlap_seen = 0;
  bit mon_on = 1'b0;

  always #2 clk = ~clk;

  spwm_gate_gen #(.CODE_W(8), .DT_W(4), .DT_PRESCALE(P)) u_spwm_gate_gen (
    .clk(clk), .rst_n(rst_n), .carrier_code(carrier_code),
    .dead_setting(dead_setting), .ref_a(ref_a), .ref_b(ref_b), .ref_c(ref_c),
    .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R9 monitor: sampled away from the active edge
  always @(negedge clk) begin
    if (mon_on && ((gate_hi & gate_lo) != 3'b000)) overlap_seen++;
  end

  task automatic apply_reset(input logic [7:0] code, input logic [3:0] dt);
    @(negedge clk);
    rst_n = 1'b0;
    carrier_code = code;
    dead_setting = dt;
    ref_a = 8'h80; ref_b = 8'h80; ref_c = 8'h80;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    rst_n = 1'b0;
    ref_a = 8'h7f; ref_b = 8'h7f; ref_c = 8'h80;
    dead_setting = 4'd0;
    repeat (5) @(negedge clk);
    chk(gate_hi == 3'b000, "R1 gate_hi in reset", gate_hi, 0);
    chk(gate_lo == 3'b000, "R1 gate_lo in reset", gate_lo, 0);
    rst_n = 1'b1;
  endtask

  // R2/R3/R4/R5: count gate high cycles over one full carrier period
  task automatic t_duty(input logic [7:0] code, input logic [7:0] rv,
                        input int exp_hi, input string tag);
    int hi_n, lo_n, win;
    apply_reset(code, 4'd0);
    ref_a = rv;
    repeat (16) @(negedge clk);
    win = 508 * (int'(code) + 1);
    hi_n = 0; lo_n = 0;
    for (int i = 0; i < win; i++) begin
      @(negedge clk);
      if (gate_hi[0]) hi_n++;
      if (gate_lo[0]) lo_n++;
    end
    chk(hi_n == exp_hi, tag, hi_n, exp_hi);
    chk(lo_n == win - exp_hi, "R5 lower gate is complement", lo_n, win - exp_hi);
  endtask

  // R6: rising edge delayed by dead-time ticks, falling edge immediate
  task automatic t_dead_rise(input logic [3:0] s);
    int n;
    int lo_min, lo_max;
    apply_reset(8'hff, s);
    repeat (80) @(negedge clk);
    chk(gate_lo[0] == 1'b1, "R6 lower gate up before step", gate_lo[0], 1);
    ref_a = 8'h7f;
    n = 0;
    @(posedge clk); #1; n++;
    chk(gate_lo[0] == 1'b0, "R6 lower gate falls on first edge", gate_lo[0], 0);
    while (!gate_hi[0] && n < 200) begin
      @(posedge clk); #1; n++;
    end
    lo_min = P * (int'(s) - 1) + 2;
    lo_max = P * int'(s) + 1;
    chk(n >= lo_min && n <= lo_max, "R6 rise delay lower bound", n, lo_min);
    chk(n <= lo_max, "R6 rise delay upper bound", n, lo_max);
    @(negedge clk);
    ref_a = 8'h80;
    @(posedge clk); #1;
    chk(gate_hi[0] == 1'b0, "R6 upper gate falls on first edge", gate_hi[0], 0);
  endtask

  // R7: setting 0 gives a one-edge path
  task automatic t_dead_zero();
    apply_reset(8'hff, 4'd0);
    repeat (10) @(negedge clk);
    ref_b = 8'h7f;
    @(posedge clk); #1;
    chk(gate_hi[1] == 1'b1, "R7 zero dead-time rise", gate_hi[1], 1);
    chk(gate_lo[1] == 1'b0, "R7 zero dead-time fall", gate_lo[1], 0);
  endtask

  // R8: a short raw pulse never reaches the output
  task automatic t_cancel();
    int seen;
    apply_reset(8'hff, 4'd15);
    repeat (80) @(negedge clk);
    seen = 0;
    ref_c = 8'h7f;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (gate_hi[2]) seen++;
    end
    ref_c = 8'h80;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (gate_hi[2]) seen++;
    end
    chk(seen == 0, "R8 cancelled rise stays low", seen, 0);
  endtask

  // R10: each phase follows its own reference
  task automatic t_phases();
    apply_reset(8'hff, 4'd1);
    ref_a = 8'h7f; ref_b = 8'h80; ref_c = 8'h7f;
    repeat (30) @(negedge clk);
    chk(gate_hi == 3'b101, "R10 upper gates per phase", gate_hi, 5);
    chk(gate_lo == 3'b010, "R10 lower gates per phase", gate_lo, 2);
    ref_c = 8'h80;
    repeat (30) @(negedge clk);
    chk(gate_hi == 3'b001, "R10 phase c alone changes", gate_hi, 1);
  endtask

  initial begin
    rst_n = 1'b0;
    carrier_code = 8'd0;
    dead_setting = 4'd0;
    ref_a = 8'h80; ref_b = 8'h80; ref_c = 8'h80;
    t_reset_state();
    mon_on = 1'b1;
    t_duty(8'd0, 8'h00, 253,      "R2 R3 duty ref 0 code 0");
    t_duty(8'd3, 8'h00, 253 * 4,  "R3 duty ref 0 code 3");
    t_duty(8'd3, 8'h7f, 507 * 4,  "R4 strict compare at top");
    t_duty(8'd1, 8'h81, 0,        "R4 never above bottom");
    t_dead_rise(4'd5);
    t_dead_rise(4'd1);
    t_dead_zero();
    t_cancel();
    t_phases();
    mon_on = 1'b0;
    chk(overlap_seen == 0, "R9 no leg overlap", overlap_seen, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule